// File: doc/BRIEF.md
# I2C SCL Phase Divider

This block derives the SCL timing base of an I2C master from a single peripheral clock. One 32-bit divider word holds two independent counts: the lower half sets the length of the SCL low phase, the upper half the length of the SCL high phase. Each phase is eight times its count plus one, in input clock cycles. Each phase is split into four equal quarters. A one-cycle strobe, tagged with the quarter number, marks the first cycle of each quarter. A bit-level engine uses these strobes to place start, stop, data-change and sampling events.

The sequencer is a three-state machine. **IDLE** is entered on reset or whenever `enable` is low. In IDLE, SCL rests high and no strobes are produced. **IDLE→LOW** is taken on the first clock edge that samples `enable` high. **LOW→HIGH** is taken after the fourth quarter of the low phase. **HIGH→LOW** is taken after the fourth quarter of the high phase. Any state goes to IDLE when `enable` is sampled low.

A divider write goes to a pending register. It is copied into the active register only on the IDLE→LOW and HIGH→LOW transitions. A phase that is already running is therefore never shortened or stretched.

Top module: `scl_phase_divider`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `scl_hi` is 1, `q_stb` is 0 and `q_idx` is 0.
- R2: Divider word bits 15:0 give the low count L and bits 31:16 give the high count H; the word is written when `cfg_we` is 1 at a clock edge.
- R3: After the edge that first samples `enable` high, SCL is low (`scl_hi`=0) for 8×(L+1) cycles, then high for 8×(H+1) cycles, repeating while enabled.
- R4: Each phase is split into four quarters of 2×(D+1) cycles, where D is that phase's count. `q_stb` is 1 exactly in the first cycle of each quarter, with `q_idx` = 0,1,2,3 giving the quarter number. `q_idx` holds its value through the quarter.
- R5: A divider written while running does not change the phase in progress or the rest of that period; it takes effect at the start of the next low phase.
- R6: When `enable` is sampled low, the next cycle shows `scl_hi`=1 and `q_stb`=0. A later enable restarts at the low phase, quarter 0.
- R7: With L = H = 0 the period is the minimum of 16 cycles, with a strobe every 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the divider; low forces IDLE |
| cfg_we | input | 1 | Write strobe for the divider word |
| cfg_wdata | input | 32 | Divider word: high count in 31:16, low count in 15:0 |
| scl_hi | output | 1 | Current phase: 1 high (or idle), 0 low |
| q_stb | output | 1 | One-cycle strobe at the start of each quarter |
| q_idx | output | 2 | Quarter number within the current phase |

## Verification
The hardest case to reach is a divider write that lands in the middle of a running period. It must be shown that the current low and high phases keep their old lengths and that the new counts take hold exactly at the next low phase. The stimulus writes a new word a few cycles into a low phase, and again inside the high phase. A behavioural period-position model then predicts every cycle across the handover. A second hard case is dropping `enable` partway through a quarter and re-enabling. This shows that the restart begins at quarter 0 of the low phase and that no leftover count carries over.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_e;
endpackage

// File: rtl/scl_div_cfg.sv
module scl_div_cfg #(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2*DIV_W-1:0] wr_data,
    input  logic               load,
    output logic [DIV_W-1:0]   act_lo,
    output logic [DIV_W-1:0]   act_hi
);
    localparam int REG_W = 2 * DIV_W;

    logic [REG_W-1:0] pend_q;
    logic [REG_W-1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (wr_en) begin
            pend_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (load) begin
            act_q <= pend_q;
        end
    end

    assign act_lo = act_q[DIV_W-1:0];
    assign act_hi = act_q[REG_W-1:DIV_W];

    // R5: active counts move only on a phase-start load
    assert_act_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> $past(load));
endmodule

// File: rtl/scl_div_seq.sv
module scl_div_seq
    import scl_div_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_lo,
    input  logic [DIV_W-1:0] div_hi,
    output logic             load,
    output logic             scl_hi,
    output logic             q_stb,
    output logic [1:0]       q_idx
);
    localparam int CNT_W = DIV_W + 1;

    scl_state_e       st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [1:0]       qtr, qtr_n;
    logic [CNT_W-1:0] lim;

    // quarter length is 2*(D+1); last count is 2*D+1
    assign lim = (st == ST_HIGH) ? {div_hi, 1'b1} : {div_lo, 1'b1};

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        qtr_n = qtr;
        load  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                st_n  = ST_LOW;
                cnt_n = '0;
                qtr_n = 2'd0;
                load  = 1'b1;
            end
            ST_LOW, ST_HIGH: begin
                if (cnt == lim) begin
                    cnt_n = '0;
                    if (qtr == 2'd3) begin
                        qtr_n = 2'd0;
                        if (st == ST_LOW) begin
                            st_n = ST_HIGH;
                        end else begin
                            st_n = ST_LOW;
                            load = 1'b1;
                        end
                    end else begin
                        qtr_n = qtr + 2'd1;
                    end
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: begin
                st_n  = ST_IDLE;
                cnt_n = '0;
                qtr_n = 2'd0;
            end
        endcase
        if (!enable) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
            qtr_n = 2'd0;
            load  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            qtr <= 2'd0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            qtr <= qtr_n;
        end
    end

    always_comb begin
        scl_hi = (st != ST_LOW);
        q_stb  = (st != ST_IDLE) && (cnt == '0);
        q_idx  = qtr;
    end

    // R6: a disabled cycle leaves SCL high with no strobe
    assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (scl_hi && !q_stb));

    // R4: a non-first quarter strobe follows the previous quarter
    assert_quarter_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_stb && q_idx != 2'd0) |-> (q_idx == $past(q_idx) + 2'd1));

    // R3: while enabled, SCL changes level only at a quarter-0 strobe
    assert_phase_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && scl_hi != $past(scl_hi)) |-> (q_stb && q_idx == 2'd0));

    // R4: quarter number holds between strobes
    assert_quarter_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && !q_stb) |-> $stable(q_idx));
endmodule

// File: rtl/scl_phase_divider.sv
module scl_phase_divider #(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cfg_we,
    input  logic [2*DIV_W-1:0] cfg_wdata,
    output logic               scl_hi,
    output logic               q_stb,
    output logic [1:0]         q_idx
);
    logic [DIV_W-1:0] act_lo;
    logic [DIV_W-1:0] act_hi;
    logic             load;

    scl_div_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .load    (load),
        .act_lo  (act_lo),
        .act_hi  (act_hi)
    );

    scl_div_seq #(.DIV_W(DIV_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .div_lo (act_lo),
        .div_hi (act_hi),
        .load   (load),
        .scl_hi (scl_hi),
        .q_stb  (q_stb),
        .q_idx  (q_idx)
    );
endmodule

// File: tb/sim_scl_phase_divider.sv
module sim_scl_phase_divider;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        scl_hi;
    logic        q_stb;
    logic [1:0]  q_idx;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural model state
    bit          m_idle = 1'b1;
    int          m_pos = 0;
    int          m_lo = 0;
    int          m_hi = 0;
    logic [31:0] m_pend = '0;

    scl_phase_divider u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .scl_hi    (scl_hi),
        .q_stb     (q_stb),
        .q_idx     (q_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // model advances on every edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_idle = 1'b1;
            m_pos  = 0;
            m_lo   = 0;
            m_hi   = 0;
            m_pend = '0;
        end else begin
            if (!enable) begin
                m_idle = 1'b1;
                m_pos  = 0;
            end else if (m_idle) begin
                m_idle = 1'b0;
                m_pos  = 0;
                m_lo   = int'(m_pend[15:0]);
                m_hi   = int'(m_pend[31:16]);
            end else begin
                m_pos++;
                if (m_pos == 8 * (m_lo + 1) + 8 * (m_hi + 1)) begin
                    m_pos = 0;
                    m_lo  = int'(m_pend[15:0]);
                    m_hi  = int'(m_pend[31:16]);
                end
            end
            if (cfg_we) m_pend = cfg_wdata;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e_hi, e_stb, e_q, off, qlen;
            if (m_idle) begin
                e_hi = 1; e_stb = 0; e_q = 0;
            end else begin
                if (m_pos < 8 * (m_lo + 1)) begin
                    e_hi = 0; off = m_pos; qlen = 2 * (m_lo + 1);
                end else begin
                    e_hi = 1; off = m_pos - 8 * (m_lo + 1); qlen = 2 * (m_hi + 1);
                end
                e_stb = (off % qlen == 0) ? 1 : 0;
                e_q   = off / qlen;
            end
            check(cur_req, int'(scl_hi), e_hi, "scl_hi");
            check(cur_req, int'(q_stb), e_stb, "q_stb");
            check(cur_req, int'(q_idx), e_q, "q_idx");
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] hi, input logic [15:0] lo);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {hi, lo};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    initial begin
        // R1: reset values
        #(CLK_PERIOD * 2);
        check("R1", int'(scl_hi), 1, "scl_hi in reset");
        check("R1", int'(q_stb), 0, "q_stb in reset");
        check("R1", int'(q_idx), 0, "q_idx in reset");
        @(negedge clk);
        rst_n = 1'b1;
        run(3);

        // R7: minimum period
        cur_req = "R7";
        @(negedge clk); enable = 1'b1;
        run(50);

        // R2 / R3 / R4: asymmetric counts
        cur_req = "R6";
        @(negedge clk); enable = 1'b0;
        run(4);
        cur_req = "R2";
        wr(16'd3, 16'd1);
        @(negedge clk); enable = 1'b1;
        cur_req = "R3";
        run(100);
        cur_req = "R4";
        wr(16'd0, 16'd5);
        run(200);

        // R5: writes mid low phase and mid high phase
        cur_req = "R5";
        wr(16'd2, 16'd2);
        run(7);
        wr(16'd1, 16'd4);
        run(150);

        // R6: drop enable inside a quarter, re-enable
        cur_req = "R6";
        run(5);
        @(negedge clk); enable = 1'b0;
        run(6);
        @(negedge clk); enable = 1'b1;
        run(120);
        @(negedge clk); enable = 1'b0;
        run(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule